// File: doc/BRIEF.md
# Multi-Mode Register Shifter

This block is a single data register that performs one single-place shift per clock cycle. A three-bit operation code selects the shift. The choices are a zero-fill move toward the MSB or toward the LSB, a rotate in either direction, and a sign-aware move in either direction. Two further codes hold the value or load a new word in parallel. An enable input gates every change to the block's state, so a controller can issue operations in any cycle it chooses.

Besides the data word, the block keeps a registered overflow flag. The flag is meaningful after a sign-aware shift toward the MSB. It is set when that shift changed the sign bit, which means the result no longer equals twice the old value. Every other enabled operation clears the flag. The width is a parameter with a default of 8 bits and must be at least 2.

Top module: `shift_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `q` becomes 0 and `ovf` becomes 0 on that edge, whatever `en` and `op` are.
- R2: With `en` low at a rising edge, `q` and `ovf` keep their values; `op` and `load_data` have no effect.
- R3: Code 000 (hold) with `en` high leaves `q` unchanged.
- R4: Code 111 (load) with `en` high copies `load_data` into `q`.
- R5: Code 001 moves every bit of `q` one place toward the MSB, puts 0 in bit 0 and drops the old MSB.
- R6: Code 010 moves every bit of `q` one place toward bit 0, puts 0 in the MSB and drops the old bit 0.
- R7: Code 011 rotates `q` toward the MSB: the old MSB lands in bit 0.
- R8: Code 100 rotates `q` toward bit 0: the old bit 0 lands in the MSB.
- R9: Code 101 (sign-aware, toward the MSB) gives the same `q` as code 001. It sets `ovf` to the XOR of the two top bits of `q` taken before the shift.
- R10: Code 110 (sign-aware, toward bit 0) keeps the MSB and also copies it into the next lower place, moves the other bits down one place, and drops the old bit 0.
- R11: Any enabled code other than 101 clears `ovf` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Lets the selected operation take effect this cycle |
| op | input | 3 | Operation code (000 hold, 001 zero-fill up, 010 zero-fill down, 011 rotate up, 100 rotate down, 101 sign-aware up, 110 sign-aware down, 111 load) |
| load_data | input | W | Word written by the load code |
| q | output | W | Register contents |
| ovf | output | 1 | Registered overflow of the last enabled operation |

## Verification
The assertions assume that `en`, `op` and `rst_n` are driven to known values at every rising edge once reset has been applied. They also assume that reset is held low for at least one edge before any operation is checked, because each property compares `q` with its value one cycle earlier. The bench holds reset low from time zero. It changes every input only at falling edges, so each operation is sampled with settled, defined codes, and it applies enable-low steps with operation codes that would change the register if they were enabled.

// File: rtl/shift_unit_pkg.sv
// Package: shared operation codes and direction helpers for the shifter.
// Assumes a three-bit code in which every value has a meaning.
package shift_unit_pkg;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'b000,
        OP_SHL   = 3'b001,
        OP_SHR   = 3'b010,
        OP_ROL   = 3'b011,
        OP_ROR   = 3'b100,
        OP_ASHL  = 3'b101,
        OP_ASHR  = 3'b110,
        OP_LOAD  = 3'b111
    } op_e;

    // True for the codes that move data toward the MSB.
    function automatic logic moves_up(op_e code);
        return (code == OP_SHL) || (code == OP_ROL) || (code == OP_ASHL);
    endfunction

    // True for the codes that move data toward bit 0.
    function automatic logic moves_down(op_e code);
        return (code == OP_SHR) || (code == OP_ROR) || (code == OP_ASHR);
    endfunction

endpackage

// File: rtl/shift_unit_next.sv
// Next-value logic: builds the register's next word from the current word.
// Each bit picks its own value, its lower neighbour or its upper neighbour.
// The end bits take a fill value that depends on the code.
// Assumes W >= 2; the enable is applied by the caller.
module shift_unit_next
    import shift_unit_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  op_e          code,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] nxt
);

    localparam int MSB = W - 1;

    logic fill_lo;   // value entering bit 0 on an upward move
    logic fill_hi;   // value entering the MSB on a downward move
    logic go_up;
    logic go_down;
    logic do_load;

    // Decode the direction and the boundary fill values from the code.
    always_comb begin
        go_up   = moves_up(code);
        go_down = moves_down(code);
        do_load = (code == OP_LOAD);
        fill_lo = (code == OP_ROL) ? cur[MSB] : 1'b0;
        case (code)
            OP_ROR:  fill_hi = cur[0];
            OP_ASHR: fill_hi = cur[MSB];
            default: fill_hi = 1'b0;
        endcase
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic from_below;
            logic from_above;

            if (i == 0) begin : g_lo_end
                assign from_below = fill_lo;
            end else begin : g_lo_mid
                assign from_below = cur[i-1];
            end

            if (i == MSB) begin : g_hi_end
                assign from_above = fill_hi;
            end else begin : g_hi_mid
                assign from_above = cur[i+1];
            end

            // Per-bit selector between load, upward, downward and keep.
            always_comb begin
                if (do_load)      nxt[i] = load_data[i];
                else if (go_up)   nxt[i] = from_below;
                else if (go_down) nxt[i] = from_above;
                else              nxt[i] = cur[i];
            end
        end
    endgenerate

endmodule

// File: rtl/shift_unit_ovf.sv
// Overflow flag register. When an enabled sign-aware upward shift takes
// place, it captures whether the two top bits of the old word differ.
// Every other enabled operation clears it, and it holds while disabled.
// Assumes top_bits carries the word's two highest bits taken before the edge.
module shift_unit_ovf
    import shift_unit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  op_e        code,
    input  logic [1:0] top_bits,
    output logic       ovf
);

    // Register the sign-change indication; reset and clear as specified.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf <= 1'b0;
        else if (en) begin
            if (code == OP_ASHL) ovf <= top_bits[1] ^ top_bits[0];
            else                 ovf <= 1'b0;
        end
    end

    AST_OVF_SIGN_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && code == OP_ASHL) |=> (ovf == ($past(top_bits[1]) != $past(top_bits[0])))); // R9

    AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && code != OP_ASHL) |=> !ovf); // R11

endmodule

// File: rtl/shift_unit.sv
// Multi-mode register shifter: one W-bit register that loads, holds,
// shifts, rotates or sign-shifts by one place per enabled clock. It also
// keeps a registered overflow flag for the sign-aware upward shift.
// Assumes W >= 2, synchronous active-low reset and a single clock.
module shift_unit
    import shift_unit_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [2:0]   op,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] q,
    output logic         ovf
);

    localparam int MSB = W - 1;

    op_e          code;
    logic [W-1:0] nxt;

    assign code = op_e'(op);

    shift_unit_next #(.W(W)) u_next (
        .cur       (q),
        .code      (code),
        .load_data (load_data),
        .nxt       (nxt)
    );

    shift_unit_ovf u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .code     (code),
        .top_bits (q[MSB -: 2]),
        .ovf      (ovf)
    );

    // Data register: reset to zero, take the next word when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= nxt;
    end

    AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(q) && $stable(ovf))); // R2

    AST_HOLD_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && code == OP_HOLD) |=> $stable(q)); // R3

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (en && code == OP_LOAD) |=> (q == $past(load_data))); // R4

    AST_SHL_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (code == OP_SHL || code == OP_ASHL)) |=> (q == {$past(q[MSB-1:0]), 1'b0})); // R5

    AST_SHR_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && code == OP_SHR) |=> (q == {1'b0, $past(q[MSB:1])})); // R6

    AST_ROL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && code == OP_ROL) |=> (q == {$past(q[MSB-1:0]), $past(q[MSB])})); // R7

    AST_ROR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && code == OP_ROR) |=> (q == {$past(q[0]), $past(q[MSB:1])})); // R8

    AST_ASHR_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && code == OP_ASHR) |=> (q[MSB] == $past(q[MSB]) && q[MSB-1:0] == $past(q[MSB:1]))); // R10

    AST_RESET_CLEARS: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> (q == '0 && !ovf)); // R1

endmodule

// File: tb/shift_unit_test.sv
// Bench for shift_unit: a vector table walked by one loop, then directed
// reset and corner-case checks.
module shift_unit_test;

    localparam int W = 8;
    localparam int NV = 26;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [2:0]   op = 3'b000;
    logic [W-1:0] load_data = '0;
    logic [W-1:0] q;
    logic         ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shift_unit #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op),
        .load_data(load_data), .q(q), .ovf(ovf)
    );

    // Vector fields: [20:18] op, [17] en, [16:9] load_data, [8:1] expected q, [0] expected ovf.
    localparam logic [20:0] TBL [0:NV-1] = '{
        {3'd7, 1'b1, 8'h6D, 8'h6D, 1'b0},  // R4 load
        {3'd1, 1'b1, 8'h00, 8'hDA, 1'b0},  // R5
        {3'd2, 1'b1, 8'h00, 8'h6D, 1'b0},  // R6
        {3'd7, 1'b1, 8'hB5, 8'hB5, 1'b0},  // R4
        {3'd3, 1'b1, 8'h00, 8'h6B, 1'b0},  // R7 MSB into bit 0
        {3'd4, 1'b1, 8'h00, 8'hB5, 1'b0},  // R8 bit 0 into MSB
        {3'd4, 1'b1, 8'h00, 8'hDA, 1'b0},  // R8
        {3'd6, 1'b1, 8'h00, 8'hED, 1'b0},  // R10 negative
        {3'd6, 1'b1, 8'h00, 8'hF6, 1'b0},  // R10
        {3'd5, 1'b1, 8'h00, 8'hEC, 1'b0},  // R9 no sign change
        {3'd7, 1'b1, 8'h4C, 8'h4C, 1'b0},  // R4
        {3'd5, 1'b1, 8'h00, 8'h98, 1'b1},  // R9 sign change 0->1
        {3'd1, 1'b0, 8'hFF, 8'h98, 1'b1},  // R2 disabled
        {3'd5, 1'b1, 8'h00, 8'h30, 1'b1},  // R9 sign change 1->0
        {3'd0, 1'b1, 8'hFF, 8'h30, 1'b0},  // R3 hold, R11 clears
        {3'd7, 1'b1, 8'h25, 8'h25, 1'b0},  // R4
        {3'd6, 1'b1, 8'h00, 8'h12, 1'b0},  // R10 positive
        {3'd5, 1'b1, 8'h00, 8'h24, 1'b0},  // R9
        {3'd7, 1'b1, 8'h80, 8'h80, 1'b0},  // R4
        {3'd5, 1'b1, 8'h00, 8'h00, 1'b1},  // R9
        {3'd2, 1'b1, 8'h00, 8'h00, 1'b0},  // R11 after shr
        {3'd7, 1'b1, 8'h01, 8'h01, 1'b0},  // R4
        {3'd4, 1'b1, 8'h00, 8'h80, 1'b0},  // R8 wrap
        {3'd3, 1'b1, 8'h00, 8'h01, 1'b0},  // R7 wrap
        {3'd5, 1'b1, 8'h00, 8'h02, 1'b0},  // R9
        {3'd7, 1'b0, 8'hAA, 8'h02, 1'b0}   // R2 load ignored
    };

    string vreq [0:NV-1] = '{
        "R4", "R5", "R6", "R4", "R7", "R8", "R8", "R10", "R10", "R9",
        "R4", "R9", "R2", "R9", "R3/R11", "R4", "R10", "R9", "R4", "R9",
        "R11", "R4", "R8", "R7", "R9", "R2"
    };

    task automatic check_q(input string req, input logic [W-1:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q actual %h expected %h", req, q, exp);
        end
    endtask

    task automatic check_ovf(input string req, input logic exp);
        checks++;
        if (ovf !== exp) begin
            errors++;
            $display("FAIL %s: ovf actual %b expected %b", req, ovf, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample after it.
    task automatic step(input logic r, input logic e, input logic [2:0] o, input logic [W-1:0] d);
        @(negedge clk);
        rst_n = r; en = e; op = o; load_data = d;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        step(1'b0, 1'b1, 3'd7, 8'hFF);
        step(1'b0, 1'b1, 3'd7, 8'hFF);
        check_q("R1", 8'h00);
        check_ovf("R1", 1'b0);

        for (int k = 0; k < NV; k++) begin
            step(1'b1, TBL[k][17], TBL[k][20:18], TBL[k][16:9]);
            check_q(vreq[k], TBL[k][8:1]);
            check_ovf(vreq[k], TBL[k][0]);
        end

        // R1: reset wins over an enabled load while q and ovf are non-zero
        step(1'b1, 1'b1, 3'd7, 8'h40);
        step(1'b1, 1'b1, 3'd5, 8'h00);
        check_q("R9", 8'h80);
        check_ovf("R9", 1'b1);
        step(1'b0, 1'b1, 3'd7, 8'h5A);
        check_q("R1", 8'h00);
        check_ovf("R1", 1'b0);

        // R2: disabled rotate leaves a set flag and the word alone
        step(1'b1, 1'b1, 3'd7, 8'h7F);
        step(1'b1, 1'b1, 3'd5, 8'h00);
        check_ovf("R9", 1'b1);
        step(1'b1, 1'b0, 3'd3, 8'h00);
        check_q("R2", 8'hFE);
        check_ovf("R2", 1'b1);

        // R11: load clears the flag
        step(1'b1, 1'b1, 3'd7, 8'h81);
        check_q("R4", 8'h81);
        check_ovf("R11", 1'b0);

        // R10: all-ones stays all-ones; R6 all-ones drains
        step(1'b1, 1'b1, 3'd7, 8'hFF);
        step(1'b1, 1'b1, 3'd6, 8'h00);
        check_q("R10", 8'hFF);
        step(1'b1, 1'b1, 3'd2, 8'h00);
        check_q("R6", 8'h7F);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule